// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory

This block models a bit-serial configuration store that shifts its contents out one bit per rising edge of the clock it receives. An internal address pointer selects the bit on the data output. The pointer moves forward only while the active-low chip enable is asserted and the reset function is idle. Loading a program leaves the pointer in place, so a second program stored directly behind the first can be fetched later without repositioning.

One pin carries both reset and output enable. A polarity strap selects how that pin is read. With the strap high, a high level resets and a low level enables the output. With the strap low, the roles are swapped. The data output is modelled as a value plus a drive enable. When the enable is low, the pin is high impedance.

After the final bit has been read, the memory stops driving its output and pulls its cascade output low. That output feeds the chip enable of the next memory in a chain, which then supplies data. Capacity is a parameter and may be 32, 64 or 128 kbit. The stored contents are computed from a pattern parameter.

Top module: `cfgrom_serial`

## Requirements
- R1: A synchronous power-on reset (`rst` high at a clock edge) clears the pointer to address 0 and sets `ceo_n` high.
- R2: On each rising clock edge with `ce_n` low, the reset function inactive and the pointer short of the end, the pointer advances by exactly one address.
- R3: While `ce_n` is high, the pointer holds, `data_en` is low and `data_q` reads 0.
- R4: With `rst_pol` = 1, `rst_oe` high is the reset function. `rst_oe` low enables the output, so `data_en` is high when `ce_n` is low.
- R5: With `rst_pol` = 0, `rst_oe` low is the reset function. `rst_oe` high enables the output.
- R6: The reset function returns the pointer to address 0 at the next clock edge, whatever the level of `ce_n`, and returns `ceo_n` high.
- R7: A pointer that has stopped, whether from `ce_n` high or because a program ended, resumes at the next address, not at address 0.
- R8: Once the last address (capacity − 1) has been clocked out, `data_en` goes low and `ceo_n` is low while `ce_n` is low. Further clocks neither wrap the pointer nor re-enable the output. `ceo_n` is high while `ce_n` is high.
- R9: The bit stored at address a is the XOR of all bits of (a AND `PATTERN`), XORed with `INVERT`. With the defaults (`PATTERN` = 17'h0B35D, `INVERT` = 0), `data_q` shows this bit for the current pointer whenever `data_en` is high.
- R10: `CAP_KBITS` selects 32, 64 or 128 kbit, giving 32768, 65536 or 131072 addresses. The default is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; one bit is presented per rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| ce_n | input | 1 | Active-low chip enable |
| rst_oe | input | 1 | Combined reset / output-enable pin |
| rst_pol | input | 1 | Polarity strap: 1 means a high `rst_oe` resets |
| data_q | output | 1 | Serial data value; 0 whenever not driven |
| data_en | output | 1 | Drive enable for the data pin; low means high impedance |
| ceo_n | output | 1 | Active-low cascade enable for the next memory |

## Verification
The bench targets four corner cases.

- **Last address.** The bench steps through the whole default capacity to reach the final address. It then checks three things: that the output releases, that the cascade output falls, and that more clocks do not wrap the pointer back to address 0. A design with an off-by-one end detection would release one bit early or late.
- **Both polarities.** Each polarity is exercised in both directions. A design with the strap inverted would reset when it should drive.
- **Reset while disabled.** The reset function is applied while the chip is disabled. A design that gates reset with the chip enable would keep a stale pointer.
- **Resuming after a pause.** Stretches of disable are followed by re-enable. A design that loses its place would restart the bit sequence at address 0.

// File: rtl/cfgrom_pkg.sv
`timescale 1ns/1ps
package cfgrom_pkg;

    // Decoded meaning of the combined reset / output-enable pin
    typedef struct packed {
        logic rst_req;
        logic oe_on;
    } pin_dec_t;

    // Output stage bundle
    typedef struct packed {
        logic bit_v;
        logic drive;
        logic casc_n;
    } out_t;

    function automatic pin_dec_t decode_pin(input logic pin, input logic pol_hi);
        pin_dec_t d;
        d.rst_req = pol_hi ? pin : ~pin;
        d.oe_on   = ~d.rst_req;
        return d;
    endfunction

    // Address width for the supported capacities (kbit)
    function automatic int addr_bits(input int kbits);
        case (kbits)
            64:      return 16;
            128:     return 17;
            default: return 15;
        endcase
    endfunction

endpackage

// File: rtl/cfgrom_ptr.sv
`timescale 1ns/1ps
module cfgrom_ptr #(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] ptr_o,
    output logic          done_o
);
    // One extra bit marks "past the last address"
    logic [AW:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (adv && !cnt[AW]) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ptr_o  = cnt[AW-1:0];
    assign done_o = cnt[AW];

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && adv && !done_o) |=> (ptr_o == $past(ptr_o) + 1'b1) || done_o);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !adv) |=> ($stable(ptr_o) && $stable(done_o)));
    // R6
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr_o == '0 && !done_o));
    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !clr) |=> done_o);

endmodule

// File: rtl/cfgrom_store.sv
`timescale 1ns/1ps
module cfgrom_store #(
    parameter int          AW      = 15,
    parameter logic [16:0] PATTERN = 17'h0B35D,
    parameter logic        INVERT  = 1'b0
) (
    input  logic [AW-1:0] addr,
    output logic          bit_o
);
    logic [AW-1:0] taps;

    // Content is computed: one AND tap per address bit, folded by XOR
    for (genvar i = 0; i < AW; i++) begin : g_tap
        assign taps[i] = addr[i] & PATTERN[i];
    end

    assign bit_o = (^taps) ^ INVERT;

endmodule

// File: rtl/cfgrom_drive.sv
`timescale 1ns/1ps
module cfgrom_drive
    import cfgrom_pkg::*;
(
    input  logic ce_n,
    input  logic oe_on,
    input  logic done,
    input  logic bit_i,
    output out_t out_o
);
    always_comb begin
        out_o.drive  = ~ce_n & oe_on & ~done;
        out_o.bit_v  = bit_i & out_o.drive;
        out_o.casc_n = ~(done & ~ce_n);
    end
endmodule

// File: rtl/cfgrom_serial.sv
`timescale 1ns/1ps
module cfgrom_serial
    import cfgrom_pkg::*;
#(
    parameter int          CAP_KBITS = 32,
    parameter logic [16:0] PATTERN   = 17'h0B35D,
    parameter logic        INVERT    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic rst_oe,
    input  logic rst_pol,
    output logic data_q,
    output logic data_en,
    output logic ceo_n
);
    localparam int AW = addr_bits(CAP_KBITS);

    pin_dec_t      dec;
    logic [AW-1:0] ptr;
    logic          ptr_done;
    logic          cur_bit;
    out_t          outs;

    assign dec = decode_pin(rst_oe, rst_pol);

    cfgrom_ptr #(.AW(AW)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .clr    (dec.rst_req),
        .adv    (~ce_n),
        .ptr_o  (ptr),
        .done_o (ptr_done)
    );

    cfgrom_store #(.AW(AW), .PATTERN(PATTERN), .INVERT(INVERT)) u_store (
        .addr  (ptr),
        .bit_o (cur_bit)
    );

    cfgrom_drive u_drive (
        .ce_n  (ce_n),
        .oe_on (dec.oe_on),
        .done  (ptr_done),
        .bit_i (cur_bit),
        .out_o (outs)
    );

    assign data_q  = outs.bit_v;
    assign data_en = outs.drive;
    assign ceo_n   = outs.casc_n;

    // R8
    tri_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_done |-> !data_en);
    // R3
    ce_off_chk: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (!data_en && ceo_n));
    // R6
    casc_clr_chk: assert property (@(posedge clk) disable iff (rst)
        dec.rst_req |=> ceo_n);

endmodule

// File: tb/cfgrom_serial_tb_top.sv
`timescale 1ns/1ps
module cfgrom_serial_tb_top;
    localparam int          CAP = 32768;
    localparam logic [16:0] PAT = 17'h0B35D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, rst_oe = 1'b0, rst_pol = 1'b1;
    logic data_q, data_en, ceo_n;

    int checks = 0, errors = 0, mptr = 0;
    bit fin = 0;

    always #2.5 clk = ~clk;

    cfgrom_serial dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .rst_oe(rst_oe), .rst_pol(rst_pol),
        .data_q(data_q), .data_en(data_en), .ceo_n(ceo_n)
    );

    // vector: {req[3:0], ce_n, rst_oe, rst_pol, cycles[7:0]}
    localparam logic [14:0] VEC [10] = '{
        {4'd2, 1'b0, 1'b0, 1'b1, 8'd10},
        {4'd3, 1'b1, 1'b0, 1'b1, 8'd4},
        {4'd7, 1'b0, 1'b0, 1'b1, 8'd6},
        {4'd4, 1'b0, 1'b1, 1'b1, 8'd2},
        {4'd4, 1'b0, 1'b0, 1'b1, 8'd5},
        {4'd5, 1'b0, 1'b1, 1'b0, 8'd7},
        {4'd5, 1'b0, 1'b0, 1'b0, 8'd1},
        {4'd3, 1'b1, 1'b1, 1'b0, 8'd3},
        {4'd6, 1'b1, 1'b0, 1'b0, 8'd2},
        {4'd9, 1'b0, 1'b1, 1'b0, 8'd9}
    };

    function automatic string rname(input int r);
        case (r)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R9";
        endcase
    endfunction

    function automatic logic bit_of(input int a);
        logic [16:0] v;
        v = a[16:0] & PAT;
        return ^v;
    endfunction

    task automatic check(input string req, input logic ce, input logic pin, input logic pol);
        logic rq, en, dq, co;
        rq = pol ? pin : ~pin;
        en = !ce && !rq && (mptr < CAP);
        dq = en ? bit_of(mptr) : 1'b0;
        co = !((mptr == CAP) && !ce);
        checks++;
        if ({data_en, data_q, ceo_n} !== {en, dq, co}) begin
            errors++;
            $display("FAIL %s en/data/ceo_n got %b%b%b exp %b%b%b (addr %0d)",
                     req, data_en, data_q, ceo_n, en, dq, co, mptr);
        end
    endtask

    task automatic step(input logic ce, input logic pin, input logic pol,
                        input string req, input bit do_chk);
        @(negedge clk);
        ce_n = ce; rst_oe = pin; rst_pol = pol;
        @(posedge clk);
        if (pol ? pin : ~pin) mptr = 0;
        else if (!ce && mptr < CAP) mptr++;
        #1;
        if (do_chk) check(req, ce, pin, pol);
    endtask

    task automatic por(input string req);
        @(negedge clk);
        rst = 1'b1; ce_n = 1'b1;
        @(posedge clk);
        mptr = 0;
        #1;
        check(req, ce_n, rst_oe, rst_pol);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // R1: power-on reset state
        repeat (2) @(posedge clk);
        #1;
        mptr = 0;
        check("R1", 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b0;

        // table walk
        for (int v = 0; v < 10; v++) begin
            for (int c = 0; c < int'(VEC[v][7:0]); c++) begin
                step(VEC[v][10], VEC[v][9], VEC[v][8], rname(int'(VEC[v][14:11])), 1'b1);
            end
        end

        // R6: reset function with polarity high, then run to the end (R10 default size)
        step(1'b0, 1'b1, 1'b1, "R6", 1'b1);
        while (mptr < CAP - 1) step(1'b0, 1'b0, 1'b1, "R10", 1'b0);
        check("R9", 1'b0, 1'b0, 1'b1);
        // R8: last bit clocked out, output releases, cascade falls
        step(1'b0, 1'b0, 1'b1, "R8", 1'b1);
        step(1'b0, 1'b0, 1'b1, "R8", 1'b1);
        step(1'b0, 1'b0, 1'b1, "R8", 1'b1);
        // R8: cascade high while disabled, low again once re-enabled
        step(1'b1, 1'b0, 1'b1, "R8", 1'b1);
        step(1'b0, 1'b0, 1'b1, "R8", 1'b1);
        // R6: reset function after exhaustion returns to address 0
        step(1'b0, 1'b1, 1'b1, "R6", 1'b1);
        step(1'b0, 1'b0, 1'b1, "R6", 1'b1);
        // R7: continue after pause
        repeat (3) step(1'b0, 1'b0, 1'b1, "R7", 1'b1);
        step(1'b1, 1'b0, 1'b1, "R7", 1'b1);
        step(1'b0, 1'b0, 1'b1, "R7", 1'b1);
        // R1: power-on reset mid-stream
        por("R1");
        step(1'b0, 1'b0, 1'b1, "R1", 1'b1);

        fin = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        if (!fin) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at addr %0d", mptr);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule